// File: doc/BRIEF.md
# Moving-Block Test Pattern Generator

This block produces a synthetic video stream that can stand in for a camera or a video input while the rest of a video pipeline is brought up. It emits one 24-bit RGB pixel for each pixel-clock cycle in which its enable input is high. Pixels are emitted in raster order, and frame-start and line-end markers travel alongside each pixel. The picture shows eight vertical color bars. A solid-color frame surrounds them, and a square block slides over the bars and bounces off the inner edge of that frame.

The active width and height, the frame thickness, the block's edge length and the block's step per frame are compile-time parameters. The frame color and the block color are also parameters. The block moves once per frame: when the last pixel of the last line is emitted, each axis advances by the step. If a step would carry the block to or past the inner frame edge, the block stops at that edge and its direction on that axis reverses. The consumer can stall the stream at any cycle by lowering the enable. The stream then resumes from the same raster position, so a downstream FIFO can pace it without losing pixels.

Top module: `moving_block_tpg`

## Requirements
- R1: While `rst_n` is low, every output is zero. The first pixel produced after reset is raster position (0,0) with `pix_sof` high. The block then starts with its top-left corner at (BORDER, BORDER) and moves toward increasing x and increasing y.
- R2: A rising clock edge with `pix_en` high produces exactly one pixel on the outputs after that edge, with `pix_vld` high. A rising clock edge with `pix_en` low drives `pix_vld`, `pix_sof`, `pix_eol` and `pix_rgb` to zero, and the raster position does not advance.
- R3: Pixels come in raster order: x runs from 0 to H_ACT-1 within a line, and lines run from 0 to V_ACT-1, after which the raster wraps to (0,0). `pix_sof` is high only with the pixel at (0,0), and `pix_eol` is high only with pixels at x = H_ACT-1.
- R4: A pixel with x < BORDER, x >= H_ACT-BORDER, y < BORDER or y >= V_ACT-BORDER carries BORDER_RGB. This takes priority over the block and the bars.
- R5: A pixel outside the frame that lies inside the block carries BLOCK_RGB. A pixel is inside the block when bx <= x < bx+BLOCK and by <= y < by+BLOCK, where (bx, by) is the block's corner.
- R6: Every other pixel carries the color of bar index i = x / (H_ACT/8), where H_ACT is a multiple of 8. Let k = 7 - i. Red is 8'hFF when k[1] is set, green is 8'hFF when k[2] is set and blue is 8'hFF when k[0] is set; otherwise each channel is 0. The channels sit in `pix_rgb` as red [23:16], green [15:8] and blue [7:0]. Bar 0 is therefore white and bar 7 is black.
- R7: The block's position changes only when the last pixel of a frame (x = H_ACT-1, y = V_ACT-1) is emitted. The pixel at that position still uses the old block position.
- R8: On each axis, a forward step sets p = p+STEP, or sets p to the upper limit and reverses direction if p+STEP reaches or passes that limit. A backward step sets p = p-STEP, or sets p to BORDER and reverses direction if p <= BORDER+STEP. The x upper limit is H_ACT-BORDER-BLOCK and the y upper limit is V_ACT-BORDER-BLOCK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_en | input | 1 | Advance enable; one pixel per cycle while high |
| pix_rgb | output | 24 | Pixel color, red in the top byte |
| pix_vld | output | 1 | Pixel on `pix_rgb` is valid |
| pix_sof | output | 1 | First pixel of a frame |
| pix_eol | output | 1 | Last pixel of a line |

## Verification
Properties check the enable-to-valid handshake on every cycle. They also check that a stalled cycle drives the outputs to zero, that the frame-start marker never appears without a valid pixel, and that the block stays within the inner frame limits on both axes. A further property checks that the block position holds still except at a frame's final accepted pixel. Whether each pixel has the right color depends on the priority between frame, block and bars and on the bounce path, so only the bench's reference model can show it. That model follows the raster and the block across dozens of frames under random stalls, through several reversals on both axes.

// File: rtl/tpg_pkg.sv
// Shared types and helpers for the moving-block pattern generator.
// Assumes: 8 bits per color channel, packed red-green-blue from MSB down.
package tpg_pkg;
    typedef logic [23:0] rgb_t;

    // Color of one of the eight vertical bars; index 0 is white, 7 is black.
    function automatic rgb_t bar_color(input logic [2:0] idx);
        logic [2:0] k;
        k = 3'd7 - idx;
        return {{8{k[1]}}, {8{k[2]}}, {8{k[0]}}};
    endfunction
endpackage

// File: rtl/tpg_raster.sv
// Raster position counter: walks x across a line and y down a frame,
// and also tracks which of the eight bars the current column belongs to.
// Assumes: H_ACT is a multiple of 8; counters advance only on step_en.
module tpg_raster #(
    parameter int H_ACT = 1920,
    parameter int V_ACT = 1080,
    localparam int XW = $clog2(H_ACT),
    localparam int YW = $clog2(V_ACT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_en,
    output logic [XW-1:0] pos_x,
    output logic [YW-1:0] pos_y,
    output logic [2:0]    bar_idx,
    output logic          line_last,
    output logic          frame_last
);
    localparam int BAR_W = H_ACT / 8;
    localparam int BW    = (BAR_W > 1) ? $clog2(BAR_W) : 1;
    localparam logic [XW-1:0] X_LAST   = XW'(H_ACT - 1);
    localparam logic [YW-1:0] Y_LAST   = YW'(V_ACT - 1);
    localparam logic [BW-1:0] BAR_LAST = BW'(BAR_W - 1);

    logic [BW-1:0] bar_cnt;

    assign line_last  = (pos_x == X_LAST);
    assign frame_last = line_last && (pos_y == Y_LAST);

    // Advance column, bar and line counters once per accepted pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_x   <= '0;
            pos_y   <= '0;
            bar_cnt <= '0;
            bar_idx <= '0;
        end else if (step_en) begin
            if (line_last) begin
                pos_x   <= '0;
                bar_cnt <= '0;
                bar_idx <= '0;
                pos_y   <= (pos_y == Y_LAST) ? '0 : pos_y + 1'b1;
            end else begin
                pos_x <= pos_x + 1'b1;
                if (bar_cnt == BAR_LAST) begin
                    bar_cnt <= '0;
                    bar_idx <= bar_idx + 1'b1;
                end else begin
                    bar_cnt <= bar_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tpg_axis_motion.sv
// One axis of block motion: steps the block corner once per frame and
// reverses at the inner frame edges, clamping to the edge on reversal.
// Assumes: SPAN - 2*BORDER > BLOCK so the travel range is non-empty.
module tpg_axis_motion #(
    parameter int SPAN   = 1920,
    parameter int BORDER = 16,
    parameter int BLOCK  = 64,
    parameter int STEP   = 4,
    parameter int W      = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    output logic [W-1:0] pos
);
    localparam int LO = BORDER;
    localparam int HI = SPAN - BORDER - BLOCK;

    logic going_back;
    int   cur;

    assign cur = int'(pos);

    // Move one step per frame and bounce at either limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos        <= W'(LO);
            going_back <= 1'b0;
        end else if (advance) begin
            if (!going_back) begin
                if (cur + STEP >= HI) begin
                    pos        <= W'(HI);
                    going_back <= 1'b1;
                end else begin
                    pos <= W'(cur + STEP);
                end
            end else begin
                if (cur <= LO + STEP) begin
                    pos        <= W'(LO);
                    going_back <= 1'b0;
                end else begin
                    pos <= W'(cur - STEP);
                end
            end
        end
    end
endmodule

// File: rtl/tpg_pixel_sel.sv
// Pixel color selection by priority: frame, then block, then bar color.
// Assumes: purely combinational; inputs describe the pixel being emitted.
module tpg_pixel_sel
    import tpg_pkg::*;
#(
    parameter int   H_ACT      = 1920,
    parameter int   V_ACT      = 1080,
    parameter int   BORDER     = 16,
    parameter int   BLOCK      = 64,
    parameter rgb_t BORDER_RGB = 24'h404040,
    parameter rgb_t BLOCK_RGB  = 24'hFF8000,
    parameter int   XW         = 11,
    parameter int   YW         = 11
) (
    input  logic [XW-1:0] pos_x,
    input  logic [YW-1:0] pos_y,
    input  logic [XW-1:0] blk_x,
    input  logic [YW-1:0] blk_y,
    input  logic [2:0]    bar_idx,
    output rgb_t          rgb
);
    int  xi, yi, bxi, byi;
    logic in_frame, in_blk;

    assign xi  = int'(pos_x);
    assign yi  = int'(pos_y);
    assign bxi = int'(blk_x);
    assign byi = int'(blk_y);

    // Region tests for the frame and the block square.
    always_comb begin
        in_frame = (xi < BORDER) || (xi >= H_ACT - BORDER) ||
                   (yi < BORDER) || (yi >= V_ACT - BORDER);
        in_blk   = (xi >= bxi) && (xi < bxi + BLOCK) &&
                   (yi >= byi) && (yi < byi + BLOCK);
    end

    // Priority mux over the three color sources.
    always_comb begin
        if (in_frame)    rgb = BORDER_RGB;
        else if (in_blk) rgb = BLOCK_RGB;
        else             rgb = bar_color(bar_idx);
    end
endmodule

// File: rtl/moving_block_tpg.sv
// Top of the moving-block pattern generator. Emits one registered pixel per
// enabled cycle with frame-start and line-end markers.
// Assumes: H_ACT multiple of 8; block fits inside the inner frame.
module moving_block_tpg
    import tpg_pkg::*;
#(
    parameter int   H_ACT      = 1920,
    parameter int   V_ACT      = 1080,
    parameter int   BORDER     = 16,
    parameter int   BLOCK      = 64,
    parameter int   STEP       = 4,
    parameter rgb_t BORDER_RGB = 24'h404040,
    parameter rgb_t BLOCK_RGB  = 24'hFF8000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pix_en,
    output logic [23:0] pix_rgb,
    output logic        pix_vld,
    output logic        pix_sof,
    output logic        pix_eol
);
    localparam int XW = $clog2(H_ACT);
    localparam int YW = $clog2(V_ACT);

    logic [XW-1:0] pos_x, blk_x;
    logic [YW-1:0] pos_y, blk_y;
    logic [2:0]    bar_idx;
    logic          line_last, frame_last, frame_step;
    rgb_t          next_rgb;

    assign frame_step = pix_en && frame_last;

    tpg_raster #(.H_ACT(H_ACT), .V_ACT(V_ACT)) u_raster (
        .clk(clk), .rst_n(rst_n), .step_en(pix_en),
        .pos_x(pos_x), .pos_y(pos_y), .bar_idx(bar_idx),
        .line_last(line_last), .frame_last(frame_last)
    );

    tpg_axis_motion #(.SPAN(H_ACT), .BORDER(BORDER), .BLOCK(BLOCK),
                      .STEP(STEP), .W(XW)) u_move_x (
        .clk(clk), .rst_n(rst_n), .advance(frame_step), .pos(blk_x)
    );

    tpg_axis_motion #(.SPAN(V_ACT), .BORDER(BORDER), .BLOCK(BLOCK),
                      .STEP(STEP), .W(YW)) u_move_y (
        .clk(clk), .rst_n(rst_n), .advance(frame_step), .pos(blk_y)
    );

    tpg_pixel_sel #(.H_ACT(H_ACT), .V_ACT(V_ACT), .BORDER(BORDER),
                    .BLOCK(BLOCK), .BORDER_RGB(BORDER_RGB),
                    .BLOCK_RGB(BLOCK_RGB), .XW(XW), .YW(YW)) u_sel (
        .pos_x(pos_x), .pos_y(pos_y), .blk_x(blk_x), .blk_y(blk_y),
        .bar_idx(bar_idx), .rgb(next_rgb)
    );

    // Register the selected pixel and its markers; zero on stalled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_rgb <= '0;
            pix_vld <= 1'b0;
            pix_sof <= 1'b0;
            pix_eol <= 1'b0;
        end else begin
            pix_vld <= pix_en;
            pix_sof <= pix_en && (pos_x == '0) && (pos_y == '0);
            pix_eol <= pix_en && line_last;
            pix_rgb <= pix_en ? next_rgb : '0;
        end
    end
endmodule

// File: rtl/tpg_checker.sv
// Protocol and motion-range checks for moving_block_tpg, bound to the top.
// Assumes: same parameters as the top; observes ports and motion state.
module tpg_checker #(
    parameter int H_ACT  = 1920,
    parameter int V_ACT  = 1080,
    parameter int BORDER = 16,
    parameter int BLOCK  = 64,
    parameter int XW     = 11,
    parameter int YW     = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pix_en,
    input logic [23:0]   pix_rgb,
    input logic          pix_vld,
    input logic          pix_sof,
    input logic          pix_eol,
    input logic          frame_last,
    input logic [XW-1:0] blk_x,
    input logic [YW-1:0] blk_y
);
    localparam int X_HI = H_ACT - BORDER - BLOCK;
    localparam int Y_HI = V_ACT - BORDER - BLOCK;

    AST_VLD_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        pix_en |=> pix_vld); // R2
    AST_STALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> (!pix_vld && !pix_sof && !pix_eol && pix_rgb == 24'h0)); // R2
    AST_SOF_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        pix_sof |-> pix_vld); // R3
    AST_EOL_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        pix_eol |-> pix_vld); // R3
    AST_BLK_X_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(blk_x) >= BORDER) && (int'(blk_x) <= X_HI)); // R8
    AST_BLK_Y_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(blk_y) >= BORDER) && (int'(blk_y) <= Y_HI)); // R8
    AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(pix_en && frame_last) |=> ($stable(blk_x) && $stable(blk_y))); // R7
endmodule

bind moving_block_tpg tpg_checker #(
    .H_ACT(H_ACT), .V_ACT(V_ACT), .BORDER(BORDER), .BLOCK(BLOCK),
    .XW(XW), .YW(YW)
) u_tpg_checker (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .pix_rgb(pix_rgb),
    .pix_vld(pix_vld), .pix_sof(pix_sof), .pix_eol(pix_eol),
    .frame_last(frame_last), .blk_x(blk_x), .blk_y(blk_y)
);

// File: tb/tb_moving_block_tpg.sv
// Bench for moving_block_tpg: reference model of raster, bars, frame and
// bouncing block, driven by directed stalls and seeded random enables.
module tb_moving_block_tpg;
    localparam int H = 64;
    localparam int V = 32;
    localparam int B = 2;
    localparam int BLK = 6;
    localparam int STP = 3;
    localparam logic [23:0] FRAME_C = 24'h404040;
    localparam logic [23:0] BLOCK_C = 24'hFF8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_en = 1'b0;
    logic [23:0] pix_rgb;
    logic        pix_vld, pix_sof, pix_eol;

    int checks = 0;
    int errors = 0;

    int mx = 0, my = 0;
    int bx = B, by = B;
    bit bx_back = 0, by_back = 0;

    always #4 clk = ~clk;

    moving_block_tpg #(.H_ACT(H), .V_ACT(V), .BORDER(B), .BLOCK(BLK),
                       .STEP(STP), .BORDER_RGB(FRAME_C), .BLOCK_RGB(BLOCK_C)) dut (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .pix_rgb(pix_rgb),
        .pix_vld(pix_vld), .pix_sof(pix_sof), .pix_eol(pix_eol)
    );

    function automatic bit in_frame(int x, int y);
        return (x < B) || (x >= H - B) || (y < B) || (y >= V - B);
    endfunction

    function automatic bit in_block(int x, int y);
        return (x >= bx) && (x < bx + BLK) && (y >= by) && (y < by + BLK);
    endfunction

    function automatic logic [23:0] exp_pixel(int x, int y);
        int k;
        if (in_frame(x, y)) return FRAME_C;
        if (in_block(x, y)) return BLOCK_C;
        k = 7 - x / (H / 8);
        return {{8{k[1]}}, {8{k[2]}}, {8{k[0]}}};
    endfunction

    function automatic string region_tag(int x, int y);
        if (in_frame(x, y)) return "R4";
        if (in_block(x, y)) return "R5/R8";
        return "R6";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at x=%0d y=%0d: actual %h expected %h", tag, mx, my, act, exp);
        end
    endtask

    task automatic move_axis(inout int p, inout bit back, input int hi);
        if (!back) begin
            if (p + STP >= hi) begin p = hi; back = 1; end
            else p = p + STP;
        end else begin
            if (p <= B + STP) begin p = B; back = 0; end
            else p = p - STP;
        end
    endtask

    // Drive one cycle at the falling edge, then check at the next falling edge.
    task automatic cycle(input bit e);
        logic [23:0] er;
        string tag;
        pix_en = e;
        er  = exp_pixel(mx, my);
        tag = region_tag(mx, my);
        @(negedge clk);
        if (e) begin
            check("R2 vld", 32'(pix_vld), 32'd1);
            check("R3 sof", 32'(pix_sof), 32'((mx == 0) && (my == 0)));
            check("R3 eol", 32'(pix_eol), 32'(mx == H - 1));
            check(tag, 32'(pix_rgb), 32'(er));
            mx++;
            if (mx == H) begin
                mx = 0;
                my++;
                if (my == V) begin
                    my = 0;
                    move_axis(bx, bx_back, H - B - BLK); // R7
                    move_axis(by, by_back, V - B - BLK); // R7
                end
            end
        end else begin
            check("R2 stall", {pix_vld, pix_sof, pix_eol, 5'd0, pix_rgb}, 32'd0);
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int bx_turns = 0;
        void'($urandom(32'd20240611));
        // R1: outputs are zero while reset is held.
        repeat (3) @(negedge clk);
        check("R1 reset", {pix_vld, pix_sof, pix_eol, 5'd0, pix_rgb}, 32'd0);
        rst_n = 1'b1;
        // R1: first enabled pixel is (0,0) with sof; block starts at corner (B,B).
        cycle(1'b1);
        // R2: a burst of stalls must not advance the raster.
        for (int i = 0; i < 20; i++) cycle(1'b0);
        // First frame at full rate covers the start position of the block.
        for (int i = 1; i < H * V; i++) cycle(1'b1);
        // R2: stall right at a frame boundary, then continue.
        for (int i = 0; i < 5; i++) cycle(1'b0);
        // Random stalls over many frames to drive several bounces (R7, R8).
        for (int f = 0; f < 40; f++) begin
            bit prev_back = bx_back;
            for (int i = 0; i < H * V; i++) begin
                while (($urandom % 8) == 0) cycle(1'b0);
                cycle(1'b1);
            end
            if (bx_back != prev_back) bx_turns++;
        end
        // R8: the run must have reversed the x axis at least twice.
        check("R8 turns", 32'(bx_turns >= 2), 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule